// File: doc/BRIEF.md
# Dual-Buffer Frame Fetch Engine

This block feeds a raster display pipeline with pixel words taken from memory. Software programs two frame descriptors, each made of a start byte address and an inclusive last-byte address. It then sets the raster enable bit. The engine walks the active descriptor in read bursts of a programmable size. It stops each burst short at the descriptor's last byte, and it pushes the returned words into an internal pixel FIFO. When a descriptor is exhausted, the engine flags end-of-frame for that buffer. It then continues with the other descriptor in dual mode, or with descriptor 0 again in single mode.

Each descriptor is sampled only when the engine starts on that buffer. Software can therefore rewrite the buffer that just finished while the other one is being read. Status flags are sticky and cleared by writing ones. An end-of-frame interrupt line is asserted when enabled and a frame flag is pending. Reads from the pixel side against an empty FIFO are recorded as an underflow. A lost-sync indication from the timing logic is recorded as well.

Register index map (reg_addr_i): 0 control, 1 raster, 2 status (write-one-to-clear), 3 start address 0, 4 last address 0, 5 start address 1, 6 last address 1.

Top module: `frame_fetch_dma`

## Requirements
- R1: After reset status_o is 0, mem_req_o is low and pix_valid_o is low.
- R2: No memory request is made while raster enable (index 1, bit 0) is 0. Once it is set, the first request goes to start address 0.
- R3: Control bits 6:4 (index 0) pick the burst size: codes 0, 1, 2, 3 and 4 give 1, 2, 4, 8 and 16 words.
- R4: While the burst code is 5, 6 or 7, no request is issued.
- R5: Each burst starts at the next unread word, with addresses advancing by 4 bytes per word. A burst is shortened so that it never reads beyond the inclusive last-byte address.
- R6: With control bit 0 clear, descriptor 0 is read over and over and only status bit 8 is set.
- R7: With control bit 0 set, buffers are read in the order 0, 1, 0, ... The end of buffer 0 sets status bit 8 and the end of buffer 1 sets status bit 9.
- R8: Writing index 2 clears each status bit whose written bit is 1 and leaves the others unchanged.
- R9: irq_o is high exactly when control bit 2 is set and status bit 8 or 9 is set.
- R10: A descriptor rewritten while the other buffer is being read is used from the next time its buffer starts.
- R11: Clearing raster enable lets the current burst complete, empties the pixel FIFO and stops requests. The next enable starts again from buffer 0.
- R12: A pixel read while raster is enabled and the FIFO is empty sets status bit 5. A read with raster disabled does not.
- R13: A pulse on sync_lost_i sets status bit 2.
- R14: Words leave the FIFO in fetch order. No burst is requested unless the FIFO has room for all of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| sync_lost_i | input | 1 | Lost-sync pulse from timing logic |
| mem_req_o | output | 1 | Burst read request |
| mem_gnt_i | input | 1 | Request accepted |
| mem_addr_o | output | AW | Burst start byte address |
| mem_len_o | output | 5 | Burst length in words |
| mem_rvalid_i | input | 1 | Read data beat valid |
| mem_rdata_i | input | DW | Read data beat |
| pix_rd_i | input | 1 | Pixel side pops a word |
| pix_valid_o | output | 1 | FIFO holds a word |
| pix_data_o | output | DW | FIFO head word |
| status_o | output | 10 | Bit 9/8 end of buffer 1/0, bit 5 underflow, bit 2 lost sync |
| irq_o | output | 1 | End-of-frame interrupt |

## Verification
Buffers are tried in several sizes: exact multiples of the burst size, lengths that end in a partial burst, and a long buffer. These separate correct ceiling truncation from plain burst stepping. Single and dual modes are run with distinct start addresses, so the request log shows both the alternation order and which status bit each buffer end sets. A descriptor is rewritten mid-frame, and the raster is stopped mid-frame, to tell a late-sampled descriptor and a correct restart apart from stale state. The pixel consumer is stalled, to show that whole-burst FIFO room gates requests.

// File: rtl/ffd_pkg.sv
package ffd_pkg;
  localparam int NUM_BUF  = 2;
  localparam int LEN_W    = 5;
  localparam int CODE_W   = 3;
  localparam logic [CODE_W-1:0] MAX_CODE = 3'd4;

  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_RASTER = 3'd1;
  localparam logic [2:0] REG_STAT   = 3'd2;
  localparam logic [2:0] REG_DESC   = 3'd3;  // start0, last0, start1, last1

  localparam int ST_SYNC  = 2;
  localparam int ST_UFLOW = 5;
  localparam int ST_EOF   = 8;  // 8 + buffer index

  typedef enum logic [1:0] {E_IDLE, E_REQ, E_DATA} eng_state_e;

  typedef struct packed {
    logic              dual_en;
    logic              eof_ie;
    logic [CODE_W-1:0] burst_code;
    logic              raster_en;
  } ctrl_t;

  function automatic logic [LEN_W-1:0] burst_words(input logic [CODE_W-1:0] code);
    burst_words = LEN_W'(1) << code;
  endfunction
endpackage

// File: rtl/ffd_regs.sv
module ffd_regs
  import ffd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [2:0]                    addr_i,
  input  logic [31:0]                   wdata_i,
  input  logic [NUM_BUF-1:0]            eof_set_i,
  input  logic                          uflow_set_i,
  input  logic                          sync_set_i,
  output ctrl_t                         ctrl_o,
  output logic [NUM_BUF-1:0][AW-1:0]    base_o,
  output logic [NUM_BUF-1:0][AW-1:0]    ceil_o,
  output logic [9:0]                    status_o,
  output logic                          irq_o
);
  ctrl_t              ctrl_q;
  logic [NUM_BUF-1:0] eof_q;
  logic               uflow_q, sync_q;
  logic               clr;

  assign clr = we_i && (addr_i == REG_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (we_i) begin
      if (addr_i == REG_CTRL) begin
        ctrl_q.dual_en    <= wdata_i[0];
        ctrl_q.eof_ie     <= wdata_i[2];
        ctrl_q.burst_code <= wdata_i[6:4];
      end
      if (addr_i == REG_RASTER) ctrl_q.raster_en <= wdata_i[0];
    end
  end

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_desc
    logic [AW-1:0] base_r, ceil_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_r <= '0;
        ceil_r <= '0;
      end else if (we_i) begin
        if (addr_i == REG_DESC + 3'(2*b))     base_r <= wdata_i[AW-1:0];
        if (addr_i == REG_DESC + 3'(2*b + 1)) ceil_r <= wdata_i[AW-1:0];
      end
    end
    assign base_o[b] = base_r;
    assign ceil_o[b] = ceil_r;

    // set wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) eof_q[b] <= 1'b0;
      else         eof_q[b] <= eof_set_i[b] | (eof_q[b] & ~(clr & wdata_i[ST_EOF+b]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uflow_q <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      uflow_q <= uflow_set_i | (uflow_q & ~(clr & wdata_i[ST_UFLOW]));
      sync_q  <= sync_set_i  | (sync_q  & ~(clr & wdata_i[ST_SYNC]));
    end
  end

  assign ctrl_o   = ctrl_q;
  assign status_o = {eof_q[1], eof_q[0], 2'b00, uflow_q, 2'b00, sync_q, 2'b00};
  assign irq_o    = ctrl_q.eof_ie & (|eof_q);
endmodule

// File: rtl/ffd_fifo.sv
module ffd_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          valid_o,
  output logic [CW-1:0] free_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign do_push = push_i && !flush_i && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop_i  && !flush_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + PW'(1);
      if (do_pop)  rp_q <= rp_q + PW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rp_q];
  assign valid_o = (cnt_q != '0);
  assign free_o  = CW'(DEPTH) - cnt_q;
endmodule

// File: rtl/ffd_engine.sv
module ffd_engine
  import ffd_pkg::*;
#(
  parameter int AW  = 32,
  parameter int FCW = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       raster_en_i,
  input  logic                       dual_en_i,
  input  logic [CODE_W-1:0]          burst_code_i,
  input  logic [NUM_BUF-1:0][AW-1:0] base_i,
  input  logic [NUM_BUF-1:0][AW-1:0] ceil_i,
  input  logic [FCW-1:0]             fifo_free_i,
  output logic                       mem_req_o,
  input  logic                       mem_gnt_i,
  output logic [AW-1:0]              mem_addr_o,
  output logic [LEN_W-1:0]           mem_len_o,
  input  logic                       mem_rvalid_i,
  output logic                       push_o,
  output logic [NUM_BUF-1:0]         eof_set_o,
  output logic [AW-1:0]              act_ceil_o
);
  eng_state_e       state_q;
  logic             cur_q, nxt;
  logic [AW-1:0]    addr_q, ceil_q;
  logic [LEN_W-1:0] beats_q, blen, len;
  logic             last_q, legal, rem_le, buf_done;
  logic [AW-1:0]    rem_words;

  assign legal     = (burst_code_i <= MAX_CODE);
  assign blen      = burst_words(burst_code_i);
  assign rem_words = ((ceil_q - addr_q) >> 2) + AW'(1);
  assign rem_le    = (rem_words <= AW'(blen));
  assign len       = rem_le ? rem_words[LEN_W-1:0] : blen;
  assign nxt       = dual_en_i ? ~cur_q : 1'b0;

  assign mem_req_o  = (state_q == E_REQ) && raster_en_i && legal &&
                      (32'(fifo_free_i) >= 32'(len));
  assign mem_addr_o = addr_q;
  assign mem_len_o  = len;
  assign act_ceil_o = ceil_q;
  assign push_o     = (state_q == E_DATA) && mem_rvalid_i && raster_en_i;
  assign buf_done   = (state_q == E_DATA) && mem_rvalid_i &&
                      (beats_q == LEN_W'(1)) && last_q;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_eof
    assign eof_set_o[b] = buf_done && (cur_q == 1'(b));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= E_IDLE;
      cur_q   <= 1'b0;
      addr_q  <= '0;
      ceil_q  <= '0;
      beats_q <= '0;
      last_q  <= 1'b0;
    end else begin
      case (state_q)
        E_IDLE: begin
          cur_q <= 1'b0;
          if (raster_en_i) begin
            addr_q  <= base_i[0];
            ceil_q  <= ceil_i[0];
            state_q <= E_REQ;
          end
        end
        E_REQ: begin
          if (!raster_en_i) begin
            state_q <= E_IDLE;
          end else if (mem_req_o && mem_gnt_i) begin
            beats_q <= len;
            last_q  <= rem_le;
            state_q <= E_DATA;
          end
        end
        E_DATA: begin
          if (mem_rvalid_i) begin
            beats_q <= beats_q - LEN_W'(1);
            if (beats_q == LEN_W'(1)) begin
              // descriptors are sampled only when a buffer starts
              if (last_q) begin
                cur_q  <= nxt;
                addr_q <= base_i[nxt];
                ceil_q <= ceil_i[nxt];
              end else begin
                addr_q <= addr_q + AW'(4);
              end
              state_q <= raster_en_i ? E_REQ : E_IDLE;
            end else begin
              addr_q <= addr_q + AW'(4);
            end
          end
        end
        default: state_q <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_fetch_dma.sv
module frame_fetch_dma
  import ffd_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int FIFO_DEPTH = 32,
  localparam int FCW       = $clog2(FIFO_DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  input  logic          sync_lost_i,
  output logic          mem_req_o,
  input  logic          mem_gnt_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [4:0]    mem_len_o,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          pix_rd_i,
  output logic          pix_valid_o,
  output logic [DW-1:0] pix_data_o,
  output logic [9:0]    status_o,
  output logic          irq_o
);
  ctrl_t                      ctrl;
  logic [NUM_BUF-1:0][AW-1:0] base, ceil;
  logic [NUM_BUF-1:0]         eof_set;
  logic [FCW-1:0]             fifo_free;
  logic [AW-1:0]              act_ceil;
  logic                       push, uflow_set, raster_en;
  logic [CODE_W-1:0]          burst_code;

  assign raster_en  = ctrl.raster_en;
  assign burst_code = ctrl.burst_code;
  assign uflow_set  = raster_en && pix_rd_i && !pix_valid_o;

  ffd_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .eof_set_i(eof_set), .uflow_set_i(uflow_set), .sync_set_i(sync_lost_i),
    .ctrl_o(ctrl), .base_o(base), .ceil_o(ceil),
    .status_o, .irq_o
  );

  ffd_engine #(.AW(AW), .FCW(FCW)) u_eng (
    .clk_i, .rst_ni,
    .raster_en_i(raster_en), .dual_en_i(ctrl.dual_en), .burst_code_i(burst_code),
    .base_i(base), .ceil_i(ceil), .fifo_free_i(fifo_free),
    .mem_req_o, .mem_gnt_i, .mem_addr_o, .mem_len_o, .mem_rvalid_i,
    .push_o(push), .eof_set_o(eof_set), .act_ceil_o(act_ceil)
  );

  ffd_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i(!raster_en), .push_i(push), .wdata_i(mem_rdata_i),
    .pop_i(pix_rd_i), .rdata_o(pix_data_o), .valid_o(pix_valid_o),
    .free_o(fifo_free)
  );
endmodule

// File: rtl/frame_fetch_dma_chk.sv
module frame_fetch_dma_chk #(
  parameter int AW  = 32,
  parameter int FCW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          raster_en,
  input logic [2:0]    burst_code,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [4:0]    mem_len_o,
  input logic [AW-1:0] act_ceil,
  input logic [FCW-1:0] fifo_free,
  input logic          reg_we_i,
  input logic [2:0]    reg_addr_i,
  input logic [31:0]   reg_wdata_i,
  input logic [1:0]    eof_set,
  input logic [9:0]    status_o,
  input logic          pix_rd_i,
  input logic          pix_valid_o
);
  logic [AW:0] burst_end;
  assign burst_end = {1'b0, mem_addr_o} + (AW+1)'({mem_len_o, 2'b00}) - (AW+1)'(1);

  a_r2_no_req_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !raster_en |-> !mem_req_o);

  a_r3_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_len_o != 5'd0) && (mem_len_o <= 5'd16));

  a_r4_no_req_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> burst_code <= 3'd4);

  a_r5_within_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> burst_end <= {1'b0, act_ceil});

  a_r8_w1c_eof0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd2 && reg_wdata_i[8] && !eof_set[0]) |=> !status_o[8]);

  a_r12_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raster_en && pix_rd_i && !pix_valid_o) |=> status_o[5]);

  a_r14_fifo_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> 32'(mem_len_o) <= 32'(fifo_free));
endmodule

bind frame_fetch_dma frame_fetch_dma_chk #(.AW(AW), .FCW(FCW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .raster_en(raster_en), .burst_code(burst_code),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_len_o(mem_len_o),
  .act_ceil(act_ceil), .fifo_free(fifo_free),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .eof_set(eof_set), .status_o(status_o), .pix_rd_i(pix_rd_i), .pix_valid_o(pix_valid_o)
);

// File: tb/frame_fetch_dma_bench.sv
`timescale 1ns/1ps
module frame_fetch_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        sync_lost = 1'b0;
  logic        mem_req, mem_gnt, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata, pix_data;
  logic [4:0]  mem_len;
  logic        pix_rd, pix_valid, irq;
  logic [9:0]  status;
  logic        drain = 1'b1;
  logic        force_rd = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  assign mem_gnt = mem_req;
  assign pix_rd  = force_rd | (drain & pix_valid);

  frame_fetch_dma u_frame_fetch_dma (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .sync_lost_i(sync_lost),
    .mem_req_o(mem_req), .mem_gnt_i(mem_gnt), .mem_addr_o(mem_addr), .mem_len_o(mem_len),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .pix_rd_i(pix_rd), .pix_valid_o(pix_valid), .pix_data_o(pix_data),
    .status_o(status), .irq_o(irq)
  );

  // memory model: data word equals its byte address
  logic [31:0] q_addr = '0;
  logic [4:0]  q_left = '0;
  logic [31:0] log_addr [0:255];
  logic [4:0]  log_len  [0:255];
  logic [31:0] pop_data [0:255];
  int n_req = 0;
  int n_pop = 0;

  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
  end

  always @(posedge clk) begin
    if (q_left != 0) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= q_addr;
      q_addr     <= q_addr + 32'd4;
      q_left     <= q_left - 5'd1;
    end else begin
      mem_rvalid <= 1'b0;
    end
    if (mem_req && mem_gnt) begin
      q_addr <= mem_addr;
      q_left <= mem_len;
      if (n_req < 256) begin
        log_addr[n_req] <= mem_addr;
        log_len[n_req]  <= mem_len;
      end
      n_req <= n_req + 1;
    end
    if (pix_rd && pix_valid) begin
      if (n_pop < 256) pop_data[n_pop] <= pix_data;
      n_pop <= n_pop + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_reqs(input int target);
    while (n_req < target) @(negedge clk);
  endtask

  task automatic raster_off();
    wr(3'd1, 32'd0);
    repeat (25) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 status", 32'(status), 32'd0);
    chk("R1 req", 32'(mem_req), 32'd0);
    chk("R1 valid", 32'(pix_valid), 32'd0);
  endtask

  task automatic t_single();
    int s, p;
    wr(3'd3, 32'h1000); wr(3'd4, 32'h102F); wr(3'd0, 32'h20);
    s = n_req; p = n_pop;
    repeat (20) @(negedge clk);
    chk("R2 idle while off", 32'(n_req), 32'(s));
    wr(3'd1, 32'd1);
    wait_reqs(s + 4);
    raster_off();
    chk("R2 first addr", log_addr[s], 32'h1000);
    chk("R5 step addr", log_addr[s+1], 32'h1010);
    chk("R5 step addr2", log_addr[s+2], 32'h1020);
    chk("R6 repeat buf0", log_addr[s+3], 32'h1000);
    chk("R3 len4", 32'(log_len[s]), 32'd4);
    chk("R6 eof0", 32'(status[8]), 32'd1);
    chk("R6 no eof1", 32'(status[9]), 32'd0);
    for (int k = 0; k < 12; k++)
      chk("R14 order", pop_data[p+k], 32'h1000 + 32'(4*k));
  endtask

  task automatic t_trunc();
    int s;
    wr(3'd2, 32'h324);
    wr(3'd4, 32'h1017);
    s = n_req;
    wr(3'd1, 32'd1);
    wait_reqs(s + 3);
    raster_off();
    chk("R5 full", 32'(log_len[s]), 32'd4);
    chk("R5 trunc addr", log_addr[s+1], 32'h1010);
    chk("R5 trunc len", 32'(log_len[s+1]), 32'd2);
    chk("R5 wrap", log_addr[s+2], 32'h1000);
  endtask

  task automatic t_codes();
    int s;
    wr(3'd4, 32'h10FF);
    for (int c = 0; c < 5; c++) begin
      wr(3'd0, 32'(c) << 4);
      s = n_req;
      wr(3'd1, 32'd1);
      wait_reqs(s + 1);
      raster_off();
      chk("R3 burst size", 32'(log_len[s]), 32'd1 << c);
    end
    for (int c = 5; c < 8; c++) begin
      wr(3'd0, 32'(c) << 4);
      s = n_req;
      wr(3'd1, 32'd1);
      repeat (30) @(negedge clk);
      chk("R4 illegal code", 32'(n_req), 32'(s));
      raster_off();
    end
  endtask

  task automatic t_dual();
    int s;
    wr(3'd2, 32'h324);
    wr(3'd4, 32'h100F); wr(3'd5, 32'h2000); wr(3'd6, 32'h200F);
    wr(3'd0, 32'h21);
    s = n_req;
    wr(3'd1, 32'd1);
    wait_reqs(s + 3);
    raster_off();
    chk("R7 buf0", log_addr[s], 32'h1000);
    chk("R7 buf1", log_addr[s+1], 32'h2000);
    chk("R7 back0", log_addr[s+2], 32'h1000);
    chk("R7 eof0", 32'(status[8]), 32'd1);
    chk("R7 eof1", 32'(status[9]), 32'd1);
  endtask

  task automatic t_w1c();
    wr(3'd2, 32'h100);
    chk("R8 clear bit8", 32'(status[8]), 32'd0);
    chk("R8 keep bit9", 32'(status[9]), 32'd1);
    wr(3'd2, 32'h0);
    chk("R8 zero no effect", 32'(status[9]), 32'd1);
    wr(3'd2, 32'h200);
    chk("R8 clear bit9", 32'(status[9]), 32'd0);
  endtask

  task automatic t_irq();
    int s;
    s = n_req;
    wr(3'd1, 32'd1);
    wait_reqs(s + 2);
    raster_off();
    chk("R9 masked", 32'(irq), 32'd0);
    wr(3'd0, 32'h25);
    chk("R9 enabled", 32'(irq), 32'd1);
    wr(3'd2, 32'h300);
    chk("R9 cleared", 32'(irq), 32'd0);
  endtask

  task automatic t_reload();
    int s;
    wr(3'd0, 32'h01);
    wr(3'd6, 32'h203F);
    s = n_req;
    wr(3'd1, 32'd1);
    wait_reqs(s + 5);
    wr(3'd3, 32'h3000); wr(3'd4, 32'h300F);
    wait_reqs(s + 21);
    raster_off();
    chk("R10 buf1 start", log_addr[s+4], 32'h2000);
    chk("R10 old ceiling kept", log_addr[s+19], 32'h203C);
    chk("R10 new base", log_addr[s+20], 32'h3000);
  endtask

  task automatic t_abort();
    int s;
    drain = 1'b0;
    s = n_req;
    wr(3'd1, 32'd1);
    wait_reqs(s + 6);
    raster_off();
    chk("R11 flushed", 32'(pix_valid), 32'd0);
    chk("R11 no req off", 32'(mem_req), 32'd0);
    s = n_req;
    wr(3'd1, 32'd1);
    wait_reqs(s + 1);
    raster_off();
    chk("R11 restart buf0", log_addr[s], 32'h3000);
    drain = 1'b1;
  endtask

  task automatic t_room();
    int s;
    wr(3'd0, 32'h40); wr(3'd3, 32'h1000); wr(3'd4, 32'h10FF);
    drain = 1'b0;
    s = n_req;
    wr(3'd1, 32'd1);
    repeat (80) @(negedge clk);
    chk("R14 stall on full", 32'(n_req), 32'(s + 2));
    drain = 1'b1;
    wait_reqs(s + 3);
    chk("R14 resume", log_addr[s+2], 32'h1080);
    raster_off();
  endtask

  task automatic t_uflow();
    wr(3'd2, 32'h324);
    wr(3'd0, 32'h70);
    wr(3'd1, 32'd1);
    @(negedge clk); force_rd = 1'b1;
    @(negedge clk); force_rd = 1'b0;
    chk("R12 underflow", 32'(status[5]), 32'd1);
    raster_off();
    wr(3'd2, 32'h20);
    chk("R12 cleared", 32'(status[5]), 32'd0);
    @(negedge clk); force_rd = 1'b1;
    @(negedge clk); force_rd = 1'b0;
    chk("R12 off ignored", 32'(status[5]), 32'd0);
  endtask

  task automatic t_sync();
    @(negedge clk); sync_lost = 1'b1;
    @(negedge clk); sync_lost = 1'b0;
    chk("R13 sync set", 32'(status[2]), 32'd1);
    wr(3'd2, 32'h4);
    chk("R13 sync clear", 32'(status[2]), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_trunc();
    t_codes();
    t_dual();
    t_w1c();
    t_irq();
    t_reload();
    t_abort();
    t_room();
    t_uflow();
    t_sync();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule